// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Sequencer

This block sits on the bus-master side of a system with eight shared, level-sensitive interrupt request lines that are driven low by slaves. Each time it is idle it picks the most urgent pending line. A per-line selection input says whether that line is serviced locally or through the bus. A locally serviced (non-vectored) line is reported to the processor side at once, and the bus is never touched. A bus-serviced (vectored) line starts an acknowledge sequence on the bus. The first strobe pulse only freezes the choice of line. Each later pulse presents the interrupt address and reads one vector byte from the low data lanes, and the slave ends that pulse with its transfer acknowledge.

A system-wide parameter sets whether vectors are one byte (two strobe pulses) or two bytes (three strobe pulses). Between pulses the strobe is held high for a fixed number of cycles. If a slave never acknowledges a vector fetch, the fetch is abandoned after a timeout and the result carries an error flag. Every outcome is signalled by a one-cycle completion pulse, and the level, mode, vector and error stay steady on the result outputs until the next sequence starts.

Request lines are assumed to be synchronous to `clk`.

Top module: `iack_ctrl`

States: `ST_IDLE` (arbitrate), `ST_FREEZE` (first strobe pulse, one cycle), `ST_GAP` (strobe high for `GAP_CYCLES`), `ST_FETCH` (strobe low, address out, waiting for the acknowledge), `ST_REPORT` (completion pulse). Transitions:
- `ST_IDLE`→`ST_REPORT` for a non-vectored winner.
- `ST_IDLE`→`ST_FREEZE` for a vectored winner.
- `ST_FREEZE`→`ST_GAP` always.
- `ST_GAP`→`ST_FETCH` when the gap has elapsed.
- `ST_FETCH`→`ST_GAP` on an acknowledge for the first byte in two-byte mode.
- `ST_FETCH`→`ST_REPORT` on an acknowledge for the last byte, or on timeout.
- `ST_REPORT`→`ST_IDLE` always.

## Requirements
- R1: A request line counts as asserted when it is 0. When several lines are asserted, the line with the smallest index wins, and its index is reported on `done_level`.
- R2: When the winning line has `vec_sel` bit 0, `done` rises one clock after the edge that sees the request. `done_vectored` is 0, `done_vector` is 0, and `inta_n` stays high throughout.
- R3: When the winning line has `vec_sel` bit 1, the first strobe pulse is exactly one cycle low. It carries no address, and no byte is sampled during it.
- R4: During every fetch pulse, `ack_addr` holds the winning level zero-extended, and it is the same in every pulse of a sequence. At all other times `ack_addr` is 0.
- R5: In a fetch pulse, `data_lo` is sampled on the clock edge where `xack_n` is seen low. The strobe returns high in the next cycle. The first byte lands in `done_vector[7:0]`. In one-byte mode, `done` follows one cycle later with `done_vector[15:8]` = 0.
- R6: In two-byte mode (`TWO_BYTE`=1), a third pulse follows the first fetch. Its byte lands in `done_vector[15:8]`.
- R7: Between consecutive pulses of one sequence, `inta_n` is high for exactly `GAP_CYCLES` cycles.
- R8: The level is frozen at the first pulse. Requests that change after it, including those of more urgent lines, do not alter the address or the reported level until `done`.
- R9: If `xack_n` is not seen low within `TIMEOUT_CYCLES` cycles of a fetch pulse, the pulse ends and `done` follows with `done_error`=1. An acknowledge seen on the last of those cycles is still accepted. Bytes not fetched read as 0.
- R10: `done` is high for one cycle per sequence, and each sequence produces exactly one `done`. A one-byte sequence takes `GAP_CYCLES`+d+3 cycles and a two-byte sequence 2·`GAP_CYCLES`+2d+4 cycles, where d is the number of cycles the slave waits before acknowledging.
- R11: While `rst_n` is low and after its release, `inta_n` is 1, `done` is 0 and `ack_addr` is 0 until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | NUM_LINES | Request lines, active low, index 0 most urgent |
| vec_sel | input | NUM_LINES | Per line: 1 = fetch a vector over the bus, 0 = local handling |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| ack_addr | output | ADDR_W | Interrupt address, valid during fetch pulses |
| xack_n | input | 1 | Slave transfer acknowledge, active low |
| data_lo | input | 8 | Low data byte from the bus |
| done | output | 1 | One-cycle completion pulse |
| done_level | output | clog2(NUM_LINES) | Serviced line index |
| done_vectored | output | 1 | 1 when the vector came over the bus |
| done_vector | output | 16 | Fetched vector, second byte in the upper half |
| done_error | output | 1 | A vector fetch timed out |

## Verification
A non-vectored result is due one cycle after the request is driven. A vectored result is due `GAP_CYCLES`+d+3 cycles after the request in one-byte mode, and 2·`GAP_CYCLES`+2d+4 cycles in two-byte mode. A timed-out first fetch completes after `GAP_CYCLES`+`TIMEOUT_CYCLES`+2 cycles. The bench stamps the cycle count when it drives each request. The scoreboard then compares the elapsed cycles against these figures at the falling edge where `done` is first seen. A slave model counts pulses, gap widths and address stability at every falling edge, and it applies an acknowledge delay chosen per test. This makes the acceptance edge of a fetch, the last accepted cycle and the first timed-out cycle land on known cycles.

// File: rtl/iack_pkg.sv
package iack_pkg;

    localparam int BYTE_W = 8;
    localparam int VEC_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREEZE,
        ST_GAP,
        ST_FETCH,
        ST_REPORT
    } iack_state_e;

endpackage

// File: rtl/iack_prio_enc.sv
// Fixed-priority resolver: lowest asserted index wins.
module iack_prio_enc #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [LW-1:0] level
);

    logic [N-1:0] win;

    // A line wins when it is asserted and no more urgent line is.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_win
            if (g == 0) begin : g_top
                assign win[g] = req[g];
            end else begin : g_rest
                assign win[g] = req[g] & ~(|req[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        level = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) level = LW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/iack_timer.sv
// Per-state cycle counter, cleared on every state change, saturating.
module iack_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != {CW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/iack_fsm.sv
// Acknowledge sequencer: state register, next-state logic, capture and outputs.
module iack_fsm
    import iack_pkg::*;
#(
    parameter int N              = 8,
    parameter int LW             = 3,
    parameter int ADDR_W         = 24,
    parameter bit TWO_BYTE       = 1'b1,
    parameter int GAP_CYCLES     = 2,
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int CW             = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [LW-1:0]     win_level,
    input  logic [N-1:0]      vec_sel,
    input  logic              xack_n,
    input  logic [BYTE_W-1:0] data_lo,
    input  logic [CW-1:0]     cnt,
    output logic              tmr_restart,
    output logic              inta_n,
    output logic [ADDR_W-1:0] ack_addr,
    output logic              done,
    output logic [LW-1:0]     done_level,
    output logic              done_vectored,
    output logic [VEC_W-1:0]  done_vector,
    output logic              done_error
);

    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYCLES - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT_CYCLES - 1);

    iack_state_e state, nxt;

    logic              byte_idx;
    logic [LW-1:0]     lvl_q;
    logic              vect_q;
    logic              err_q;
    logic [VEC_W-1:0]  vec_q;

    logic acked, timed_out, last_byte;

    assign acked     = (state == ST_FETCH) && !xack_n;
    assign timed_out = (state == ST_FETCH) && xack_n && (cnt == TMO_LAST);
    assign last_byte = !TWO_BYTE || byte_idx;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (any_req) nxt = vec_sel[win_level] ? ST_FREEZE : ST_REPORT;
            end
            ST_FREEZE: nxt = ST_GAP;
            ST_GAP: begin
                if (cnt == GAP_LAST) nxt = ST_FETCH;
            end
            ST_FETCH: begin
                if (acked)          nxt = last_byte ? ST_REPORT : ST_GAP;
                else if (timed_out) nxt = ST_REPORT;
            end
            ST_REPORT: nxt = ST_IDLE;
        endcase
    end

    assign tmr_restart = (nxt != state);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // level latch and vector capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_idx <= 1'b0;
            lvl_q    <= '0;
            vect_q   <= 1'b0;
            err_q    <= 1'b0;
            vec_q    <= '0;
        end else begin
            if (state == ST_IDLE && any_req) begin
                lvl_q    <= win_level;
                vect_q   <= vec_sel[win_level];
                err_q    <= 1'b0;
                vec_q    <= '0;
                byte_idx <= 1'b0;
            end
            if (acked) begin
                if (byte_idx) vec_q[VEC_W-1:BYTE_W] <= data_lo;
                else          vec_q[BYTE_W-1:0]     <= data_lo;
                byte_idx <= 1'b1;
            end
            if (timed_out) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        inta_n        = !(state == ST_FREEZE || state == ST_FETCH);
        ack_addr      = (state == ST_FETCH) ? ADDR_W'(lvl_q) : '0;
        done          = (state == ST_REPORT);
        done_level    = lvl_q;
        done_vectored = vect_q;
        done_vector   = vec_q;
        done_error    = err_q;
    end

endmodule

// File: rtl/iack_ctrl.sv
// Top: master-side interrupt arbitration and vectored acknowledge.
module iack_ctrl
    import iack_pkg::*;
#(
    parameter int NUM_LINES      = 8,
    parameter int ADDR_W         = 24,
    parameter bit TWO_BYTE       = 1'b1,
    parameter int GAP_CYCLES     = 2,
    parameter int TIMEOUT_CYCLES = 1024,
    localparam int LW            = $clog2(NUM_LINES),
    localparam int MAXC          = (GAP_CYCLES > TIMEOUT_CYCLES) ? GAP_CYCLES : TIMEOUT_CYCLES,
    localparam int CW            = $clog2(MAXC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_n,
    input  logic [NUM_LINES-1:0] vec_sel,
    output logic                 inta_n,
    output logic [ADDR_W-1:0]    ack_addr,
    input  logic                 xack_n,
    input  logic [BYTE_W-1:0]    data_lo,
    output logic                 done,
    output logic [LW-1:0]        done_level,
    output logic                 done_vectored,
    output logic [VEC_W-1:0]     done_vector,
    output logic                 done_error
);

    logic          any_req;
    logic [LW-1:0] win_level;
    logic          tmr_restart;
    logic [CW-1:0] cnt;

    iack_prio_enc #(.N(NUM_LINES), .LW(LW)) u_prio (
        .req   (~irq_n),
        .any   (any_req),
        .level (win_level)
    );

    iack_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .cnt     (cnt)
    );

    iack_fsm #(
        .N              (NUM_LINES),
        .LW             (LW),
        .ADDR_W         (ADDR_W),
        .TWO_BYTE       (TWO_BYTE),
        .GAP_CYCLES     (GAP_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .CW             (CW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .any_req       (any_req),
        .win_level     (win_level),
        .vec_sel       (vec_sel),
        .xack_n        (xack_n),
        .data_lo       (data_lo),
        .cnt           (cnt),
        .tmr_restart   (tmr_restart),
        .inta_n        (inta_n),
        .ack_addr      (ack_addr),
        .done          (done),
        .done_level    (done_level),
        .done_vectored (done_vectored),
        .done_vector   (done_vector),
        .done_error    (done_error)
    );

endmodule

// File: rtl/iack_ctrl_chk.sv
// Protocol checker, attached to every iack_ctrl instance.
module iack_ctrl_chk #(
    parameter int GAP_CYCLES     = 2,
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int ADDR_W         = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inta_n,
    input logic              xack_n,
    input logic [ADDR_W-1:0] ack_addr,
    input logic              done,
    input logic              done_vectored,
    input logic              done_error
);

    localparam int SAT = 1 << 20;

    int   hi_run;
    int   lo_run;
    logic in_seq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= 0;
            in_seq <= 1'b0;
        end else begin
            if (inta_n) begin
                lo_run <= 0;
                if (hi_run < SAT) hi_run <= hi_run + 1;
            end else begin
                hi_run <= 0;
                if (lo_run < SAT) lo_run <= lo_run + 1;
            end
            if (done)         in_seq <= 1'b0;
            else if (!inta_n) in_seq <= 1'b1;
        end
    end

    a_r7_gap_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(inta_n) && in_seq) |-> (hi_run == GAP_CYCLES));

    a_r9_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n |-> (lo_run < TIMEOUT_CYCLES));

    a_r4_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        inta_n |-> (ack_addr == '0));

    a_r8_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!inta_n && $past(!inta_n)) |-> $stable(ack_addr));

    a_r5_ack_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!inta_n && !xack_n && in_seq) |=> inta_n);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_local_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_vectored) |-> ($past(inta_n) && inta_n));

    a_r9_error_only_vectored: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_error) |-> done_vectored);

endmodule

bind iack_ctrl iack_ctrl_chk #(
    .GAP_CYCLES     (GAP_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .ADDR_W         (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .inta_n        (inta_n),
    .xack_n        (xack_n),
    .ack_addr      (ack_addr),
    .done          (done),
    .done_vectored (done_vectored),
    .done_error    (done_error)
);

// File: tb/iack_ctrl_test.sv
`timescale 1ns/1ps

// Behavioural slave: answers fetch pulses, records pulse count, gaps, address.
module iack_slave_model #(
    parameter int GAP = 3,
    parameter int AW  = 24
) (
    input  logic          clk,
    input  logic          inta_n,
    input  logic [AW-1:0] ack_addr,
    input  logic          done,
    input  int            delay,
    input  int            mute_from,
    output logic          xack_n,
    output logic [7:0]    data,
    output int            pulses,
    output logic          gap_bad,
    output logic          addr_bad,
    output logic [AW-1:0] fetch_addr
);
    logic prev = 1'b1;
    logic done_q = 1'b0;
    int   hi_run = 0;
    int   lowcnt = 0;

    initial begin
        xack_n = 1'b1; data = 8'h00; pulses = 0;
        gap_bad = 1'b0; addr_bad = 1'b0; fetch_addr = '0;
    end

    always @(negedge clk) begin
        automatic int pno;
        automatic bit fell;
        if (done_q) begin
            pulses = 0; gap_bad = 1'b0; addr_bad = 1'b0; fetch_addr = '0;
        end
        fell = prev && !inta_n;
        pno  = fell ? pulses + 1 : pulses;
        if (!inta_n) begin
            if (fell && pno >= 2 && hi_run != GAP) gap_bad = 1'b1;
            hi_run = 0;
            if (pno >= 2) begin
                if ((pno > 2 || !fell) && ack_addr != fetch_addr) addr_bad = 1'b1;
                fetch_addr = ack_addr;
                if ((pno - 2) < mute_from && lowcnt >= delay) begin
                    xack_n = 1'b0;
                    data   = 8'h80 | 8'((pno - 2) << 6) | {5'd0, ack_addr[2:0]};
                end
                lowcnt = lowcnt + 1;
            end else if (ack_addr != '0) begin
                addr_bad = 1'b1;
            end
        end else begin
            if (ack_addr != '0) addr_bad = 1'b1;
            xack_n = 1'b1;
            lowcnt = 0;
            hi_run = hi_run + 1;
        end
        pulses = pno;
        prev   = inta_n;
        done_q = done;
    end
endmodule

module iack_ctrl_test;
    localparam int GAP = 3;
    localparam int TMO = 8;
    localparam int AW  = 24;

    typedef struct {
        int          lvl;
        bit          vect;
        logic [15:0] vec;
        bit          err;
        int          pulses;
        int          lat;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0] irq0 = 8'hFF, irq1 = 8'hFF, vsel0 = 8'hFF, vsel1 = 8'hFF;
    logic xack0, xack1, inta0, inta1, done0, done1, vd0, vd1, err0, err1;
    logic [7:0] d0, d1;
    logic [AW-1:0] addr0, addr1, fa0, fa1;
    logic [2:0] lvl0, lvl1;
    logic [15:0] vec0, vec1;
    int dly0 = 0, dly1 = 0, mf0 = 2, mf1 = 2;
    int pul0, pul1;
    logic gb0, gb1, ab0, ab1;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int st0 = 0, st1 = 0;
    exp_t q0[$];
    exp_t q1[$];

    iack_ctrl #(.ADDR_W(AW), .TWO_BYTE(1'b1), .GAP_CYCLES(GAP), .TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq0), .vec_sel(vsel0), .inta_n(inta0),
        .ack_addr(addr0), .xack_n(xack0), .data_lo(d0), .done(done0),
        .done_level(lvl0), .done_vectored(vd0), .done_vector(vec0), .done_error(err0));

    iack_ctrl #(.ADDR_W(AW), .TWO_BYTE(1'b0), .GAP_CYCLES(GAP), .TIMEOUT_CYCLES(TMO)) uut_one (
        .clk(clk), .rst_n(rst_n), .irq_n(irq1), .vec_sel(vsel1), .inta_n(inta1),
        .ack_addr(addr1), .xack_n(xack1), .data_lo(d1), .done(done1),
        .done_level(lvl1), .done_vectored(vd1), .done_vector(vec1), .done_error(err1));

    iack_slave_model #(.GAP(GAP), .AW(AW)) slv0 (
        .clk(clk), .inta_n(inta0), .ack_addr(addr0), .done(done0), .delay(dly0),
        .mute_from(mf0), .xack_n(xack0), .data(d0), .pulses(pul0), .gap_bad(gb0),
        .addr_bad(ab0), .fetch_addr(fa0));

    iack_slave_model #(.GAP(GAP), .AW(AW)) slv1 (
        .clk(clk), .inta_n(inta1), .ack_addr(addr1), .done(done1), .delay(dly1),
        .mute_from(mf1), .xack_n(xack1), .data(d1), .pulses(pul1), .gap_bad(gb1),
        .addr_bad(ab1), .fetch_addr(fa1));

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic exp_t mk(int l, bit v, logic [15:0] vec, bit e, int p, int lat);
        exp_t x;
        x.lvl = l; x.vect = v; x.vec = vec; x.err = e; x.pulses = p; x.lat = lat;
        return x;
    endfunction

    // Monitor side of the scoreboard.
    task automatic score(int inst, logic [2:0] lvl, logic vd, logic [15:0] vec, logic err,
                         int pul, logic gb, logic ab, logic [AW-1:0] fa, int st);
        exp_t e;
        if (inst == 0) begin
            if (q0.size() == 0) begin chk(1'b0, "R10", "unexpected done uut", 1, 0); return; end
            e = q0.pop_front();
        end else begin
            if (q1.size() == 0) begin chk(1'b0, "R10", "unexpected done uut_one", 1, 0); return; end
            e = q1.pop_front();
        end
        chk(lvl == e.lvl[2:0], "R1", "done_level", lvl, e.lvl);
        chk(vd == e.vect, "R2", "done_vectored", vd, e.vect);
        chk(vec == e.vec, "R5 R6", "done_vector", vec, e.vec);
        chk(err == e.err, "R9", "done_error", err, e.err);
        chk(pul == e.pulses, "R3", "strobe pulses", pul, e.pulses);
        chk(!ab, "R4", "address outside fetch or unstable", ab, 0);
        if (e.pulses >= 2) begin
            chk(!gb, "R7", "gap width", gb, 0);
            chk(fa == AW'(e.lvl), "R4", "fetch address", fa, e.lvl);
        end
        if (e.lat >= 0) chk((cyc - st) == e.lat, "R10", "latency", cyc - st, e.lat);
    endtask

    always @(negedge clk) begin
        if (rst_n && done0) score(0, lvl0, vd0, vec0, err0, pul0, gb0, ab0, fa0, st0);
        if (rst_n && done1) score(1, lvl1, vd1, vec1, err1, pul1, gb1, ab1, fa1, st1);
    end

    task automatic wait_done(int inst);
        do @(negedge clk); while (!(inst == 0 ? done0 : done1));
    endtask

    // Driver side of the scoreboard.
    task automatic run(int inst, logic [7:0] act, logic [7:0] vs, int d, int mf, exp_t e);
        @(negedge clk);
        if (inst == 0) begin
            vsel0 = vs; dly0 = d; mf0 = mf; q0.push_back(e); st0 = cyc; irq0 = ~act;
            wait_done(0); irq0 = 8'hFF;
        end else begin
            vsel1 = vs; dly1 = d; mf1 = mf; q1.push_back(e); st1 = cyc; irq1 = ~act;
            wait_done(1); irq1 = 8'hFF;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog expired: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(inta0 && inta1, "R11", "strobe in reset", {inta0, inta1}, 2'b11);
        chk(!done0 && !done1, "R11", "done in reset", {done0, done1}, 0);
        chk(addr0 == '0 && addr1 == '0, "R11", "address in reset", addr0 | addr1, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(inta0 && !done0 && addr0 == '0, "R11", "idle after reset", {inta0, done0}, 2'b10);

        // R1 priority, R6 two-byte vector
        run(0, 8'b0100_1000, 8'hFF, 0, 2, mk(3, 1, 16'hC383, 0, 3, 2*GAP + 4));
        // R2 local line wins over vectored ones
        run(0, 8'b1010_1100, 8'b1111_1011, 0, 2, mk(2, 0, 16'h0000, 0, 0, 1));
        // R5 delayed acknowledge, least urgent line
        run(0, 8'b1000_0000, 8'hFF, 2, 2, mk(7, 1, 16'hC787, 0, 3, 2*GAP + 2*2 + 4));
        // R9 acknowledge on the last allowed cycle is accepted
        run(0, 8'b0000_0001, 8'hFF, TMO - 1, 2, mk(0, 1, 16'hC080, 0, 3, 2*GAP + 2*(TMO-1) + 4));
        // R9 one cycle later times out on the first fetch
        run(0, 8'b0001_0000, 8'hFF, TMO, 2, mk(4, 1, 16'h0000, 1, 2, GAP + TMO + 2));
        // R9 second byte missing: first byte kept, upper zero
        run(0, 8'b0100_0000, 8'hFF, 0, 1, mk(6, 1, 16'h0086, 1, 3, 2*GAP + TMO + 3));
        // R2 line 0 local
        run(0, 8'b0000_0001, 8'h00, 0, 2, mk(0, 0, 16'h0000, 0, 0, 1));

        // R8 a more urgent line arriving after the first pulse waits its turn
        @(negedge clk);
        vsel0 = 8'hFF; dly0 = 0; mf0 = 2;
        q0.push_back(mk(5, 1, 16'hC585, 0, 3, -1));
        q0.push_back(mk(1, 1, 16'hC181, 0, 3, -1));
        irq0 = ~8'b0010_0000;
        do @(negedge clk); while (inta0);
        irq0 = ~8'b0010_0010;
        wait_done(0);
        irq0 = ~8'b0000_0010;
        wait_done(0);
        irq0 = 8'hFF;
        repeat (3) @(negedge clk);

        // R5 one-byte mode
        run(1, 8'b0000_0100, 8'hFF, 1, 2, mk(2, 1, 16'h0082, 0, 2, GAP + 1 + 3));
        // R9 one-byte timeout
        run(1, 8'b0010_0000, 8'hFF, 0, 0, mk(5, 1, 16'h0000, 1, 2, GAP + TMO + 2));
        // R2 one-byte instance, local line
        run(1, 8'b0000_0010, 8'b1111_1101, 0, 2, mk(1, 0, 16'h0000, 0, 0, 1));

        repeat (5) @(negedge clk);
        chk(q0.size() == 0, "R10", "missing done uut", q0.size(), 0);
        chk(q1.size() == 0, "R10", "missing done uut_one", q1.size(), 0);
        summary();
        $finish;
    end
endmodule